// File: doc/BRIEF.md
# Nested Trap State Stack

This block keeps the processor context that must survive a chain of nested traps. When a trap is taken it captures the current condition codes, address-space identifier, processor state and window pointer. It packs them into one state word and stores that word, together with the two program counters and the trap type, in the slot for the current trap level. It then puts the processor in privileged mode, forms the trap vector in its trap-base register, tells the fetch side where to resume, and raises the trap level.

A return request has two forms. The retry form repeats the trapped instruction. The done form skips past it. Either form pops the top slot, restores the saved context and lowers the trap level. When several requests arrive in the same cycle, a trap outranks a return, and retry outranks done. The level just below the maximum is the last one taken normally: the trap that climbs from it to the top also sets the red-state bit. A trap at the top level, or a return at level zero, changes nothing and is reported on an error pulse.

Top module: `trap_state_stack`

## Requirements
- R1: After reset the trap level is 0, the processor state equals PSTATE_RST (default 0), the trap-base register is 0, the current trap type reads 0, and every valid or error pulse is low.
- R2: A trap taken at level L below MAX_LVL saves the context in slot L and sets the level to L+1. The processor state becomes 0x015, which is alternate globals (bit 0), privileged (bit 2) and FP enabled (bit 4) with all other bits clear, except as R5 describes.
- R3: On a taken trap the trap-base register becomes {tb_base, nest, trap_type, 5'b00000}. The nest bit is bit 14 and is 1 when the new trap level exceeds 1, that is when the trap was taken at a nonzero level.
- R4: One cycle after a taken trap, redir_vld is 1, redir_pc equals the new trap-base value and redir_npc equals that value plus 4.
- R5: A trap taken at level MAX_LVL-1 also sets the red-state bit (bit 5), giving a processor state of 0x035, and moves the level to MAX_LVL.
- R6: A trap request at level MAX_LVL pulses maxtl_err one cycle later. The trap level, processor state and trap-base register stay unchanged, and no redirect is issued.
- R7: A retry at level L>0 redirects with redir_pc equal to the program counter saved in slot L-1 and redir_npc equal to the next program counter saved there.
- R8: A done at level L>0 redirects with redir_pc equal to the next program counter saved in slot L-1 and redir_npc equal to that value plus 4.
- R9: Any return at level L>0 pulses rest_vld. It drives the condition codes, ASI and window saved in slot L-1 on rest_ccr, rest_asi and rest_cwp, restores the processor state saved there, and sets the level to L-1.
- R10: A return request at level 0 pulses ret_illegal one cycle later. Level and processor state stay unchanged, and there is no redirect or restore.
- R11: A trap request in the same cycle as a return request is handled as a trap only. A retry and a done together are handled as a retry.
- R12: cur_tt shows the trap type saved in slot L-1 while the level L is above 0, and shows 0 at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_type | input | 9 | Trap type of the requested trap |
| done_req | input | 1 | Return, skipping the trapped instruction |
| retry_req | input | 1 | Return, re-executing the trapped instruction |
| cur_pc | input | ADDR_W | Current program counter |
| cur_npc | input | ADDR_W | Current next program counter |
| cur_ccr | input | CCR_W | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_cwp | input | 8 | Current window pointer |
| tb_base | input | ADDR_W-15 | Upper bits of the trap-base register |
| tl | output | LVL_W | Current trap level |
| pstate | output | 12 | Processor state |
| tbr | output | ADDR_W | Trap-base register |
| cur_tt | output | 9 | Trap type at the current level |
| redir_vld | output | 1 | Fetch redirect valid |
| redir_pc | output | ADDR_W | Resume program counter |
| redir_npc | output | ADDR_W | Resume next program counter |
| rest_vld | output | 1 | Restored context valid |
| rest_ccr | output | CCR_W | Restored condition codes |
| rest_asi | output | 8 | Restored ASI |
| rest_cwp | output | 8 | Restored window pointer |
| maxtl_err | output | 1 | Trap requested at the top level |
| ret_illegal | output | 1 | Return requested at level 0 |

## Verification
A wrong stack index or trap level shows up only when a return reads the slot back. Restored fields then come from the wrong trap, so the bench unwinds a full four-deep nest, giving each level distinct values, and compares every field at every pop. A wrong processor-state or nest bit shows on pstate and tbr in the cycle after the trap. A lost or extra level increment shows at once on tl, and then again as an early ret_illegal or maxtl_err several operations later.

// File: rtl/trap_state_stack.sv
module trap_state_stack #(
  parameter int MAX_LVL = 4,
  parameter int ADDR_W = 64,
  parameter int CCR_W = 8,
  parameter logic [11:0] PSTATE_RST = 12'h000,
  localparam int LVL_W = $clog2(MAX_LVL + 1),
  localparam int TT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic [TT_W-1:0]   trap_type,
  input  logic              done_req,
  input  logic              retry_req,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] cur_npc,
  input  logic [CCR_W-1:0]  cur_ccr,
  input  logic [7:0]        cur_asi,
  input  logic [7:0]        cur_cwp,
  input  logic [ADDR_W-16:0] tb_base,
  output logic [LVL_W-1:0]  tl,
  output logic [11:0]       pstate,
  output logic [ADDR_W-1:0] tbr,
  output logic [TT_W-1:0]   cur_tt,
  output logic              redir_vld,
  output logic [ADDR_W-1:0] redir_pc,
  output logic [ADDR_W-1:0] redir_npc,
  output logic              rest_vld,
  output logic [CCR_W-1:0]  rest_ccr,
  output logic [7:0]        rest_asi,
  output logic [7:0]        rest_cwp,
  output logic              maxtl_err,
  output logic              ret_illegal
);
  localparam int SW = CCR_W + 32;
  localparam int DEPTH = 1 << LVL_W;
  localparam logic [11:0] PS_ENTRY = 12'h015;
  localparam logic [11:0] PS_RED = 12'h020;
  localparam logic [LVL_W-1:0] TOP = LVL_W'(MAX_LVL);
  localparam logic [LVL_W-1:0] LAST = LVL_W'(MAX_LVL - 1);

  logic [LVL_W-1:0]  tl_q;
  logic [11:0]       pst_q;
  logic [ADDR_W-1:0] tbr_q;
  logic [SW-1:0]     st_word [DEPTH];
  logic [ADDR_W-1:0] st_pc   [DEPTH];
  logic [ADDR_W-1:0] st_npc  [DEPTH];
  logic [TT_W-1:0]   st_tt   [DEPTH];

  wire take_trap = trap_req && (tl_q != TOP);
  wire trap_err  = trap_req && (tl_q == TOP);
  wire any_ret   = !trap_req && (done_req || retry_req);
  wire do_ret    = any_ret && (tl_q != '0);
  wire ret_bad   = any_ret && (tl_q == '0);
  wire [LVL_W-1:0] rd_idx = tl_q - 1'b1;

  wire [ADDR_W-1:0] vec = {tb_base, (tl_q != '0), trap_type, 5'b00000};
  wire [SW-1:0] pack_word = {cur_ccr, cur_asi, 4'b0000, pst_q, cur_cwp};
  wire [SW-1:0] rd_word = st_word[rd_idx];
  wire [ADDR_W-1:0] rd_npc = st_npc[rd_idx];

  always_ff @(posedge clk) begin
    if (take_trap) begin
      st_word[tl_q] <= pack_word;
      st_pc[tl_q]   <= cur_pc;
      st_npc[tl_q]  <= cur_npc;
      st_tt[tl_q]   <= trap_type;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tl_q        <= '0;
      pst_q       <= PSTATE_RST;
      tbr_q       <= '0;
      redir_vld   <= 1'b0;
      redir_pc    <= '0;
      redir_npc   <= '0;
      rest_vld    <= 1'b0;
      rest_ccr    <= '0;
      rest_asi    <= '0;
      rest_cwp    <= '0;
      maxtl_err   <= 1'b0;
      ret_illegal <= 1'b0;
    end else begin
      redir_vld   <= take_trap || do_ret;
      rest_vld    <= do_ret;
      maxtl_err   <= trap_err;
      ret_illegal <= ret_bad;
      if (take_trap) begin
        tl_q      <= tl_q + 1'b1;
        pst_q     <= (tl_q == LAST) ? (PS_ENTRY | PS_RED) : PS_ENTRY;
        tbr_q     <= vec;
        redir_pc  <= vec;
        redir_npc <= vec + ADDR_W'(4);
      end else if (do_ret) begin
        tl_q      <= rd_idx;
        pst_q     <= rd_word[19:8];
        rest_ccr  <= rd_word[SW-1:32];
        rest_asi  <= rd_word[31:24];
        rest_cwp  <= rd_word[7:0];
        redir_pc  <= retry_req ? st_pc[rd_idx] : rd_npc;
        redir_npc <= retry_req ? rd_npc : rd_npc + ADDR_W'(4);
      end
    end
  end

  assign tl = tl_q;
  assign pstate = pst_q;
  assign tbr = tbr_q;
  assign cur_tt = (tl_q == '0) ? '0 : st_tt[rd_idx];

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tl_q <= TOP);
  // R2
  entry_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> (pst_q[0] && pst_q[2] && pst_q[4] && redir_vld &&
                   tl_q == $past(tl_q) + 1'b1));
  // R6
  top_trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_err |=> ($stable(tl_q) && $stable(pst_q) && $stable(tbr_q) &&
                  !redir_vld && maxtl_err));
  // R8
  done_npc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ret && !retry_req) |=> (redir_npc == redir_pc + ADDR_W'(4)));
  // R10
  empty_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_bad |=> ($stable(tl_q) && $stable(pst_q) && ret_illegal &&
                 !rest_vld && !redir_vld));
  // R9
  pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_ret |=> (rest_vld && tl_q == $past(tl_q) - 1'b1));
endmodule

// File: tb/trap_state_stack_tb.sv
module trap_state_stack_tb_top;
  localparam int MAXL = 4;
  localparam int AW = 64;
  localparam logic [AW-16:0] BASE = 49'h0_1234_5678_9ABC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trap_req = 0, done_req = 0, retry_req = 0;
  logic [8:0] trap_type = '0;
  logic [AW-1:0] cur_pc = '0, cur_npc = '0;
  logic [7:0] cur_ccr = '0, cur_asi = '0, cur_cwp = '0;
  logic [2:0] tl;
  logic [11:0] pstate;
  logic [AW-1:0] tbr, redir_pc, redir_npc;
  logic [8:0] cur_tt;
  logic redir_vld, rest_vld, maxtl_err, ret_illegal;
  logic [7:0] rest_ccr, rest_asi, rest_cwp;

  trap_state_stack #(.MAX_LVL(MAXL), .ADDR_W(AW), .CCR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
    .done_req(done_req), .retry_req(retry_req), .cur_pc(cur_pc), .cur_npc(cur_npc),
    .cur_ccr(cur_ccr), .cur_asi(cur_asi), .cur_cwp(cur_cwp), .tb_base(BASE),
    .tl(tl), .pstate(pstate), .tbr(tbr), .cur_tt(cur_tt), .redir_vld(redir_vld),
    .redir_pc(redir_pc), .redir_npc(redir_npc), .rest_vld(rest_vld),
    .rest_ccr(rest_ccr), .rest_asi(rest_asi), .rest_cwp(rest_cwp),
    .maxtl_err(maxtl_err), .ret_illegal(ret_illegal));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int exp_tl = 0;
  logic [11:0] exp_pst = 12'h000;
  logic [AW-1:0] exp_tbr = '0;
  logic [AW-1:0] m_pc [8], m_npc [8];
  logic [7:0] m_ccr [8], m_asi [8], m_cwp [8];
  logic [11:0] m_pst [8];
  logic [8:0] m_tt [8];

  task automatic chk(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic chk_level(input string r);
    chk(AW'(tl), AW'(exp_tl), {r, " level"});
    chk(AW'(pstate), AW'(exp_pst), {r, " pstate"});
    chk(tbr, exp_tbr, {r, " tbr"});
    // R12
    chk(AW'(cur_tt), (exp_tl == 0) ? '0 : AW'(m_tt[exp_tl-1]), {r, " R12 cur_tt"});
  endtask

  task automatic fire_trap(input logic [AW-1:0] pc, input logic [7:0] cc, asi, cwp,
                           input logic [8:0] tt, input logic also_done, input string r);
    int lvl = exp_tl;
    @(negedge clk);
    cur_pc = pc; cur_npc = pc + 4; cur_ccr = cc; cur_asi = asi; cur_cwp = cwp;
    trap_type = tt; trap_req = 1; done_req = also_done;
    @(negedge clk);
    trap_req = 0; done_req = 0;
    if (lvl == MAXL) begin
      chk(AW'(maxtl_err), 1, {r, " R6 maxtl_err"});
      chk(AW'(redir_vld), 0, {r, " R6 no redirect"});
    end else begin
      m_pc[lvl] = pc; m_npc[lvl] = pc + 4; m_ccr[lvl] = cc; m_asi[lvl] = asi;
      m_cwp[lvl] = cwp; m_tt[lvl] = tt; m_pst[lvl] = exp_pst;
      exp_pst = (lvl == MAXL - 1) ? 12'h035 : 12'h015;
      exp_tbr = {BASE, (lvl != 0), tt, 5'b00000};
      exp_tl = lvl + 1;
      chk(AW'(maxtl_err), 0, {r, " R6 no error"});
      chk(AW'(redir_vld), 1, {r, " R4 redir_vld"});
      chk(redir_pc, exp_tbr, {r, " R4 redir_pc"});
      chk(redir_npc, exp_tbr + 4, {r, " R4 redir_npc"});
      chk(AW'(rest_vld), 0, {r, " R11 no restore"});
    end
    chk_level(r);
  endtask

  task automatic fire_ret(input logic retry, input logic dn, input string r);
    int lvl = exp_tl;
    @(negedge clk);
    retry_req = retry; done_req = dn;
    @(negedge clk);
    retry_req = 0; done_req = 0;
    if (lvl == 0) begin
      chk(AW'(ret_illegal), 1, {r, " R10 ret_illegal"});
      chk(AW'(rest_vld), 0, {r, " R10 no restore"});
      chk(AW'(redir_vld), 0, {r, " R10 no redirect"});
    end else begin
      exp_tl = lvl - 1;
      exp_pst = m_pst[lvl-1];
      chk(AW'(ret_illegal), 0, {r, " R10 no illegal"});
      chk(AW'(rest_vld), 1, {r, " R9 rest_vld"});
      chk(AW'(rest_ccr), AW'(m_ccr[lvl-1]), {r, " R9 ccr"});
      chk(AW'(rest_asi), AW'(m_asi[lvl-1]), {r, " R9 asi"});
      chk(AW'(rest_cwp), AW'(m_cwp[lvl-1]), {r, " R9 cwp"});
      chk(AW'(redir_vld), 1, {r, " redir_vld"});
      if (retry) begin
        chk(redir_pc, m_pc[lvl-1], {r, " R7 retry pc"});
        chk(redir_npc, m_npc[lvl-1], {r, " R7 retry npc"});
      end else begin
        chk(redir_pc, m_npc[lvl-1], {r, " R8 done pc"});
        chk(redir_npc, m_npc[lvl-1] + 4, {r, " R8 done npc"});
      end
    end
    chk_level(r);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_level("R1");
    chk(AW'({redir_vld, rest_vld, maxtl_err, ret_illegal}), 0, "R1 pulses low");
  endtask

  task automatic t_nest_up;
    fire_trap(64'h0000_1000, 8'h11, 8'h80, 8'h03, 9'h041, 0, "R2 R3 first");
    fire_trap(64'h0000_2000, 8'h22, 8'h81, 8'h05, 9'h068, 0, "R2 R3 nested");
    fire_trap(64'hFFFF_0000_3000, 8'h33, 8'h14, 8'h06, 9'h1FF, 0, "R2 third");
  endtask

  task automatic t_red;
    fire_trap(64'h0000_4000, 8'h44, 8'h04, 8'h01, 9'h024, 0, "R5 red");
  endtask

  task automatic t_overflow;
    fire_trap(64'h0000_5000, 8'h55, 8'h55, 8'h02, 9'h010, 0, "R6 top");
  endtask

  task automatic t_unwind;
    fire_ret(1, 0, "R7 retry");
    fire_ret(0, 1, "R8 done");
    fire_ret(1, 1, "R11 retry over done");
    fire_ret(0, 1, "R9 last pop");
  endtask

  task automatic t_illegal;
    fire_ret(0, 1, "R10 empty");
  endtask

  task automatic t_priority;
    fire_trap(64'h0000_6000, 8'h66, 8'h10, 8'h07, 9'h0A0, 1, "R11 trap over done");
    fire_ret(0, 1, "R11 pop");
  endtask

  initial begin
    t_reset();
    t_nest_up();
    t_red();
    t_overflow();
    t_unwind();
    t_illegal();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule